// File: doc/BRIEF.md
# Scan Test Application Sequencer

This block runs a full-scan circuit under test through a complete manufacturing test. For every combinational test vector it loads the present-state bits into the scan chains through a number of shift clocks. It then spends exactly one normal-mode clock to capture the next state and the primary-output response. The load of each vector also unloads the state that the previous vector captured. A final unload after the last capture drains the chains.

The flip-flops of the circuit may be spread over several chains of different lengths that share one test-control line. The shift phase always lasts as many cycles as the longest chain. Shorter chains receive leading don't-care bits.

Vectors come from a constant image given as a parameter, or from an input port that the environment updates from the vector index output. Every vector carries its expected next state, its expected primary outputs and per-bit compare masks. Any unmasked difference sets a sticky mismatch flag. A done flag marks the end of the run.

Top module: `scan_apply_seq`

## Requirements
- R1: After reset, and whenever no run is in progress, `tc` is 1, `vec_idx` is 0, and `busy`, `done` and `mismatch` are 0 (`done` and `mismatch` keep their value from a completed run until the next accepted start).
- R2: A `start` pulse seen while idle is accepted. `busy` is 1 from the next cycle for exactly (NCOMB+1)·MAXLEN + NCOMB cycles, where MAXLEN is the longest chain length.
- R3: Within a run, each vector gets MAXLEN cycles with `tc`=0 (shift) followed by one cycle with `tc`=1 (capture). A final MAXLEN shift cycles follow the last capture, giving NCOMB·MAXLEN+MAXLEN shift cycles in total.
- R4: In load cycle j (0..MAXLEN-1), chain c of length Lc receives state bit MAXLEN-1-j when that index is below Lc, and 0 otherwise. So at capture, flop i of chain c (flop 0 nearest `scan_in`) holds state bit i.
- R5: `pi` carries the active vector's input bits in the capture cycle and is 0 in shift and idle cycles.
- R6: `po` is compared with the expected outputs in the capture cycle, under the output mask.
- R7: In unload cycle j of the phase after a capture, `scan_out[c]` is compared with expected next-state bit Lc-1-j of chain c when j < Lc. Later unload cycles and the first vector's load are not compared.
- R8: A mask bit of 0 makes the matching expected bit a don't-care. A mask bit of 1 enables the compare.
- R9: `mismatch` is sticky through a run and is cleared only by an accepted start.
- R10: `done` rises in the cycle after the last unload cycle and is cleared by an accepted start.
- R11: A `start` pulse while `busy` is 1 has no effect on the run length or the sequence.
- R12: `use_ext`=1 takes vectors from `ext_vec`; otherwise vector k is ROM bits [k·VEC_W +: VEC_W]. Fields from bit 0 upward are: input bits (NPI), present state (NCH·MAXLEN, chain c bit i at c·MAXLEN+i), expected outputs (NPO), expected next state (same layout), output mask (NPO), state mask (NCH·MAXLEN).
- R13: `vec_idx` gives the index of the vector being loaded or captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Run request pulse |
| use_ext | input | 1 | 1 selects the external vector port |
| ext_vec | input | VEC_W | External vector for index `vec_idx` |
| scan_out | input | NCH | Serial outputs of the chains |
| po | input | NPO | Primary outputs of the circuit under test |
| tc | output | 1 | Test control: 0 shift, 1 normal/capture |
| scan_in | output | NCH | Serial inputs of the chains |
| pi | output | NPI | Primary inputs of the circuit under test |
| vec_idx | output | clog2(NCOMB+1) | Active vector index |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed |
| mismatch | output | 1 | Sticky unmasked response difference |

## Verification
The bench uses two chains of unequal length (3 and 4) and a small modelled circuit whose next-state and output functions are recomputed in the bench to fill both the ROM image and the external vectors. Clean runs from both sources, with several seeds, show the ordering and padding of the load and the sequence length. A sweep injects a single stuck difference into each real next-state bit and each output bit in turn. Each fault must raise the flag when its mask bit is set and stay silent when it is cleared. This separates an off-by-one in the unload index, a mask applied to the wrong field, and a comparison done in the wrong cycle. A start pulse in mid-run shows that the run is not restarted.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_CAPT  = 2'd2,
    SQ_DRAIN = 2'd3
  } sq_state_e;

  // Width of a counter that must hold values 0..n-1 (at least one bit).
  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int MAXLEN = 4,
  parameter int NCOMB  = 5,
  parameter int BW     = 2,
  parameter int VW     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output sq_state_e       state,
  output logic [BW-1:0]   bit_cnt,
  output logic [VW-1:0]   vec_cnt,
  output logic            busy,
  output logic            done,
  output logic            accept,
  output logic            capt,
  output logic            unload
);

  localparam logic [BW-1:0] BIT_LAST = BW'(MAXLEN - 1);
  localparam logic [VW-1:0] VEC_LAST = VW'(NCOMB - 1);

  sq_state_e       state_q, state_d;
  logic [BW-1:0]   bit_q, bit_d;
  logic [VW-1:0]   vec_q, vec_d;
  logic            done_q, done_d;
  logic            seq_en;
  logic            bit_end;

  assign bit_end = (bit_q == BIT_LAST);
  assign accept  = (state_q == SQ_IDLE) && start;
  assign seq_en  = (state_q != SQ_IDLE) || start;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    vec_d   = vec_q;
    done_d  = done_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_SHIFT;
          bit_d   = '0;
          vec_d   = '0;
          done_d  = 1'b0;
        end
      end
      SQ_SHIFT: begin
        if (bit_end) begin
          state_d = SQ_CAPT;
          bit_d   = '0;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
      SQ_CAPT: begin
        vec_d   = vec_q + 1'b1;
        state_d = (vec_q == VEC_LAST) ? SQ_DRAIN : SQ_SHIFT;
      end
      SQ_DRAIN: begin
        if (bit_end) begin
          state_d = SQ_IDLE;
          bit_d   = '0;
          vec_d   = '0;
          done_d  = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      bit_q   <= '0;
      vec_q   <= '0;
      done_q  <= 1'b0;
    end else if (seq_en) begin
      state_q <= state_d;
      bit_q   <= bit_d;
      vec_q   <= vec_d;
      done_q  <= done_d;
    end
  end

  assign state   = state_q;
  assign bit_cnt = bit_q;
  assign vec_cnt = vec_q;
  assign busy    = (state_q != SQ_IDLE);
  assign done    = done_q;
  assign capt    = (state_q == SQ_CAPT);
  assign unload  = ((state_q == SQ_SHIFT) && (vec_q != '0)) || (state_q == SQ_DRAIN);

endmodule

// File: rtl/scan_seq_src.sv
module scan_seq_src #(
  parameter int NCOMB = 5,
  parameter int VEC_W = 31,
  parameter int VW    = 3,
  parameter logic [NCOMB*VEC_W-1:0] ROM = '0
) (
  input  logic             use_ext,
  input  logic [VEC_W-1:0] ext_vec,
  input  logic [VW-1:0]    idx,
  output logic [VEC_W-1:0] vec
);

  logic [VEC_W-1:0] rom_ent [NCOMB];
  logic [VEC_W-1:0] rom_sel;

  for (genvar k = 0; k < NCOMB; k++) begin : g_ent
    assign rom_ent[k] = ROM[k*VEC_W +: VEC_W];
  end

  always_comb begin
    rom_sel = '0;
    for (int k = 0; k < NCOMB; k++) begin
      if (int'(idx) == k) rom_sel = rom_ent[k];
    end
  end

  assign vec = use_ext ? ext_vec : rom_sel;

endmodule

// File: rtl/scan_seq_drive.sv
module scan_seq_drive
  import scan_seq_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int MAXLEN = 4,
  parameter int NPI    = 3,
  parameter int BW     = 2,
  parameter logic [NCH*8-1:0] CHAIN_LENS = 16'h0403
) (
  input  sq_state_e            state,
  input  logic [BW-1:0]        bit_cnt,
  input  logic [NCH*MAXLEN-1:0] st_bits,
  input  logic [NPI-1:0]       vec_pi,
  output logic                 tc,
  output logic [NCH-1:0]       scan_in,
  output logic [NPI-1:0]       pi
);

  logic load_cyc;
  int   pos;

  assign load_cyc = (state == SQ_SHIFT);
  assign pos      = MAXLEN - 1 - int'(bit_cnt);
  assign tc       = !((state == SQ_SHIFT) || (state == SQ_DRAIN));
  assign pi       = (state == SQ_CAPT) ? vec_pi : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_chain
    localparam int LC = int'(CHAIN_LENS[c*8 +: 8]);
    always_comb begin
      scan_in[c] = 1'b0;
      if (load_cyc && (pos < LC)) scan_in[c] = st_bits[c*MAXLEN + pos];
    end
  end

endmodule

// File: rtl/scan_seq_cmp.sv
module scan_seq_cmp #(
  parameter int NCH    = 2,
  parameter int MAXLEN = 4,
  parameter int NPO    = 2,
  parameter int BW     = 2,
  parameter logic [NCH*8-1:0] CHAIN_LENS = 16'h0403
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  capt,
  input  logic                  unload,
  input  logic [BW-1:0]         bit_cnt,
  input  logic [NCH-1:0]        scan_out,
  input  logic [NPO-1:0]        po,
  input  logic [NPO-1:0]        exp_po,
  input  logic [NPO-1:0]        mask_po,
  input  logic [NCH*MAXLEN-1:0] exp_ns,
  input  logic [NCH*MAXLEN-1:0] mask_ns,
  output logic                  mismatch
);

  localparam int SW = NCH * MAXLEN;

  logic [SW-1:0]  ens_q, mns_q;
  logic [NCH-1:0] chain_miss;
  logic           po_miss;
  logic           mm_q, mm_d;
  int             j;

  assign j       = int'(bit_cnt);
  assign po_miss = capt && (|((po ^ exp_po) & mask_po));

  for (genvar c = 0; c < NCH; c++) begin : g_obs
    localparam int LC = int'(CHAIN_LENS[c*8 +: 8]);
    always_comb begin
      chain_miss[c] = 1'b0;
      if (unload && (j < LC)) begin
        chain_miss[c] = mns_q[c*MAXLEN + LC - 1 - j] &&
                        (scan_out[c] != ens_q[c*MAXLEN + LC - 1 - j]);
      end
    end
  end

  always_comb begin
    if (clear) mm_d = 1'b0;
    else       mm_d = mm_q || po_miss || (|chain_miss);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ens_q <= '0;
      mns_q <= '0;
    end else if (capt) begin
      ens_q <= exp_ns;
      mns_q <= mask_ns;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mm_q <= 1'b0;
    else        mm_q <= mm_d;
  end

  assign mismatch = mm_q;

endmodule

// File: rtl/scan_apply_seq.sv
module scan_apply_seq
  import scan_seq_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int MAXLEN = 4,
  parameter logic [NCH*8-1:0] CHAIN_LENS = 16'h0403,
  parameter int NPI    = 3,
  parameter int NPO    = 2,
  parameter int NCOMB  = 5,
  parameter logic [NCOMB*(NPI+2*NPO+3*NCH*MAXLEN)-1:0] ROM = '0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic                                  use_ext,
  input  logic [NPI+2*NPO+3*NCH*MAXLEN-1:0]     ext_vec,
  input  logic [NCH-1:0]                        scan_out,
  input  logic [NPO-1:0]                        po,
  output logic                                  tc,
  output logic [NCH-1:0]                        scan_in,
  output logic [NPI-1:0]                        pi,
  output logic [$clog2(NCOMB+1)-1:0]            vec_idx,
  output logic                                  busy,
  output logic                                  done,
  output logic                                  mismatch
);

  localparam int SW     = NCH * MAXLEN;
  localparam int VEC_W  = NPI + 2*NPO + 3*SW;
  localparam int BW     = cnt_w(MAXLEN);
  localparam int VW     = $clog2(NCOMB+1);
  localparam int ST_LO  = NPI;
  localparam int EPO_LO = ST_LO + SW;
  localparam int ENS_LO = EPO_LO + NPO;
  localparam int MPO_LO = ENS_LO + SW;
  localparam int MNS_LO = MPO_LO + NPO;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  sq_state_e        state;
  logic [BW-1:0]    bit_cnt;
  logic [VW-1:0]    vec_cnt;
  logic             accept, capt, unload;
  logic [VEC_W-1:0] vec;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  scan_seq_ctrl #(
    .MAXLEN (MAXLEN), .NCOMB (NCOMB), .BW (BW), .VW (VW)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .state   (state),
    .bit_cnt (bit_cnt),
    .vec_cnt (vec_cnt),
    .busy    (busy),
    .done    (done),
    .accept  (accept),
    .capt    (capt),
    .unload  (unload)
  );

  scan_seq_src #(
    .NCOMB (NCOMB), .VEC_W (VEC_W), .VW (VW), .ROM (ROM)
  ) u_src (
    .use_ext (use_ext),
    .ext_vec (ext_vec),
    .idx     (vec_cnt),
    .vec     (vec)
  );

  scan_seq_drive #(
    .NCH (NCH), .MAXLEN (MAXLEN), .NPI (NPI), .BW (BW), .CHAIN_LENS (CHAIN_LENS)
  ) u_drive (
    .state   (state),
    .bit_cnt (bit_cnt),
    .st_bits (vec[ST_LO +: SW]),
    .vec_pi  (vec[0 +: NPI]),
    .tc      (tc),
    .scan_in (scan_in),
    .pi      (pi)
  );

  scan_seq_cmp #(
    .NCH (NCH), .MAXLEN (MAXLEN), .NPO (NPO), .BW (BW), .CHAIN_LENS (CHAIN_LENS)
  ) u_cmp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear    (accept),
    .capt     (capt),
    .unload   (unload),
    .bit_cnt  (bit_cnt),
    .scan_out (scan_out),
    .po       (po),
    .exp_po   (vec[EPO_LO +: NPO]),
    .mask_po  (vec[MPO_LO +: NPO]),
    .exp_ns   (vec[ENS_LO +: SW]),
    .mask_ns  (vec[MNS_LO +: SW]),
    .mismatch (mismatch)
  );

  assign vec_idx = vec_cnt;

endmodule

// File: rtl/scan_apply_seq_chk.sv
module scan_apply_seq_chk #(
  parameter int NPI = 3,
  parameter int VW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           tc,
  input logic [NPI-1:0] pi,
  input logic [VW-1:0]  vec_idx,
  input logic           busy,
  input logic           done,
  input logic           mismatch
);

  a_r1_idle_state: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tc && (vec_idx == '0)));

  a_r3_one_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tc) |=> !tc);

  a_r5_pi_quiet_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |-> (pi == '0));

  a_r9_mismatch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mismatch) |=> mismatch);

  a_r10_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (!busy || (vec_idx >= $past(vec_idx))));

endmodule

bind scan_apply_seq scan_apply_seq_chk #(.NPI(NPI), .VW(VW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .tc       (tc),
  .pi       (pi),
  .vec_idx  (vec_idx),
  .busy     (busy),
  .done     (done),
  .mismatch (mismatch)
);

// File: tb/scan_apply_seq_bench.sv
module scan_apply_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH    = 2;
  localparam int MAXLEN = 4;
  localparam int NPI    = 3;
  localparam int NPO    = 2;
  localparam int NCOMB  = 5;
  localparam int VEC_W  = NPI + 2*NPO + 3*NCH*MAXLEN;
  localparam int RUN_LEN = (NCOMB+1)*MAXLEN + NCOMB;
  localparam logic [7:0] ST_VALID = 8'hF7;

  function automatic logic [7:0] cut_ns(input logic [2:0] p, input logic [7:0] s);
    logic [7:0] n;
    n = {s[6:0], s[7]} ^ {5'b0, p} ^ 8'h5A;
    return n & ST_VALID;
  endfunction

  function automatic logic [1:0] cut_po(input logic [2:0] p, input logic [7:0] s);
    return {^s, s[0] ^ p[2]};
  endfunction

  // Vector fields from bit 0: pi, state, exp po, exp ns, po mask, ns mask.
  function automatic logic [VEC_W-1:0] mk_vec(input int k, input int seed,
                                              input logic [1:0] mpo, input logic [7:0] mns);
    logic [7:0] st;
    logic [2:0] p;
    st = 8'(k*37 + seed*11 + 5) & ST_VALID;
    p  = 3'(k*5 + seed);
    return {mns, mpo, cut_ns(p, st), cut_po(p, st), st, p};
  endfunction

  function automatic logic [NCOMB*VEC_W-1:0] build_rom();
    logic [NCOMB*VEC_W-1:0] r;
    r = '0;
    for (int k = 0; k < NCOMB; k++) r[k*VEC_W +: VEC_W] = mk_vec(k, 0, 2'b11, ST_VALID);
    return r;
  endfunction

  localparam logic [NCOMB*VEC_W-1:0] ROM_IMG = build_rom();

  logic clk, rst_n, start, use_ext;
  logic [VEC_W-1:0] ext_vec;
  logic [NCH-1:0] scan_out, scan_in;
  logic [NPO-1:0] po;
  logic tc, busy, done, mismatch;
  logic [NPI-1:0] pi;
  logic [2:0] vec_idx;

  int         cur_seed;
  logic [1:0] cur_mpo;
  logic [7:0] cur_mns;
  logic [7:0] fault_ns;
  logic [1:0] fault_po;

  logic [2:0] c0;
  logic [3:0] c1;
  logic [7:0] cut_s;

  int n_checks, n_fail;
  bit timed_out;

  scan_apply_seq #(.ROM(ROM_IMG)) u_scan_apply_seq (
    .clk (clk), .rst_n (rst_n), .start (start), .use_ext (use_ext),
    .ext_vec (ext_vec), .scan_out (scan_out), .po (po), .tc (tc),
    .scan_in (scan_in), .pi (pi), .vec_idx (vec_idx), .busy (busy),
    .done (done), .mismatch (mismatch)
  );

  // Circuit under test: chain0 length 3, chain1 length 4.
  assign cut_s    = {c1, 1'b0, c0};
  assign scan_out = {c1[3], c0[2]};
  assign po       = cut_po(pi, cut_s) ^ fault_po;
  assign ext_vec  = mk_vec(int'(vec_idx), cur_seed, cur_mpo, cur_mns);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0 <= '0;
      c1 <= '0;
    end else if (!tc) begin
      c0 <= {c0[1:0], scan_in[0]};
      c1 <= {c1[2:0], scan_in[1]};
    end else if (busy) begin
      c0 <= (cut_ns(pi, cut_s) ^ fault_ns) & 3'h7;
      c1 <= 4'((cut_ns(pi, cut_s) ^ fault_ns) >> 4);
    end
  end

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input bit ext, input int seed, input logic [1:0] mpo,
                     input logic [7:0] mns, input logic [7:0] fns, input logic [1:0] fpo,
                     input bit poke, input bit exp_mm);
    int cyc, lo, hi, bad_st, bad_pi, bad_quiet;
    logic [VEC_W-1:0] v;
    use_ext = ext; cur_seed = seed; cur_mpo = mpo; cur_mns = mns;
    fault_ns = fns; fault_po = fpo;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(done == 1'b0, "R10 done cleared by start", done, 0);
    chk(mismatch == 1'b0, "R9 mismatch cleared by start", mismatch, 0);
    cyc = 0; lo = 0; hi = 0; bad_st = 0; bad_pi = 0; bad_quiet = 0;
    while (busy && cyc < 100) begin
      cyc++;
      if (!tc) begin
        lo++;
        if (pi != '0) bad_quiet++;
      end else begin
        hi++;
        v = mk_vec(int'(vec_idx), ext ? seed : 0, 2'b11, ST_VALID);
        if ((cut_s & ST_VALID) != v[10:3]) bad_st++;
        if (pi != v[2:0]) bad_pi++;
      end
      start = (poke && (cyc == 10 || cyc == 27));
      @(negedge clk);
    end
    start = 1'b0;
    chk(cyc == RUN_LEN, "R2/R11 run length", cyc, RUN_LEN);
    chk(lo == (NCOMB+1)*MAXLEN, "R3 shift cycles", lo, (NCOMB+1)*MAXLEN);
    chk(hi == NCOMB, "R3 capture cycles", hi, NCOMB);
    chk(bad_st == 0, "R4/R12/R13 loaded state", bad_st, 0);
    chk(bad_pi == 0, "R5 capture inputs", bad_pi, 0);
    chk(bad_quiet == 0, "R5 quiet inputs in shift", bad_quiet, 0);
    chk(done == 1'b1, "R10 done at end", done, 1);
    chk(mismatch == exp_mm, "R6/R7/R8/R9 mismatch", mismatch, exp_mm);
    chk(tc == 1'b1 && vec_idx == 0, "R1 idle after run", {tc, vec_idx}, 4'h8);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    timed_out = 1'b1;
  end

  initial begin
    n_checks = 0; n_fail = 0; timed_out = 1'b0;
    start = 0; use_ext = 0; cur_seed = 0; cur_mpo = 2'b11; cur_mns = ST_VALID;
    fault_ns = '0; fault_po = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(tc == 1'b1 && busy == 1'b0, "R1 reset tc/busy", {tc, busy}, 2'b10);
    chk(vec_idx == 0 && done == 0 && mismatch == 0, "R1 reset idx/flags",
        {vec_idx, done, mismatch}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tc == 1'b1 && busy == 1'b0, "R1 idle after release", {tc, busy}, 2'b10);

    // R12 internal image, clean.
    run(1'b0, 0, 2'b11, ST_VALID, 8'h00, 2'b00, 1'b0, 1'b0);
    // R11 start pulses in mid-run.
    run(1'b0, 0, 2'b11, ST_VALID, 8'h00, 2'b00, 1'b1, 1'b0);
    // R12 external source, several seeds.
    for (int s = 1; s < 4; s++) run(1'b1, s, 2'b11, ST_VALID, 8'h00, 2'b00, 1'b0, 1'b0);

    // R7/R8 sweep every real next-state bit.
    for (int b = 0; b < 8; b++) begin
      if (b == 3) continue;
      run(1'b1, b+2, 2'b11, ST_VALID, 8'(1 << b), 2'b00, 1'b0, 1'b1);
      run(1'b1, b+2, 2'b11, ST_VALID & ~8'(1 << b), 8'(1 << b), 2'b00, 1'b0, 1'b0);
    end
    // R6/R8 sweep output bits.
    for (int b = 0; b < 2; b++) begin
      run(1'b1, 7, 2'b11, ST_VALID, 8'h00, 2'(1 << b), 1'b0, 1'b1);
      run(1'b1, 7, ~2'(1 << b), ST_VALID, 8'h00, 2'(1 << b), 1'b0, 1'b0);
    end
    // R9 sticky through a pulsed run with an internal-source fault.
    run(1'b0, 0, 2'b11, ST_VALID, 8'h00, 2'b01, 1'b1, 1'b1);
    // R9/R10 flags hold while idle.
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && mismatch == 1'b1, "R9/R10 flags hold in idle", {done, mismatch}, 2'b11);
    run(1'b0, 0, 2'b11, ST_VALID, 8'h00, 2'b00, 1'b0, 1'b0);

    if (timed_out) chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  always @(posedge timed_out) begin
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule